// File: doc/BRIEF.md
# Dual Quadrature Odometer Counter

This block tracks the travel of a left and a right wheel from their quadrature encoders. Each wheel has two encoder phases, called A and B here. The counter for a wheel steps once on each low-to-high transition of its A phase. The level of B in that cycle sets the direction. Each wheel has a signed 16-bit position counter that wraps around at both ends.

The host loads an 8-bit polarity mask. Before B is tested, it is XORed with one bit of this mask, so the host can reverse the counting sense of each wheel without rewiring. All four encoder inputs are asynchronous and pass through two-flop synchronizers. The host reads the counters through a snapshot. A one-cycle strobe copies both counters into output registers in a single edge, so reading the four bytes one after another gives one consistent position pair.

Top module: `odo_dual_counter`

## Requirements
- R1: After reset, both counters, all four snapshot output bytes and the polarity mask are zero.
- R2: On a rising edge of a wheel's A input, if B XOR its mask bit is 0, that wheel's counter increments by one.
- R3: On a rising edge of a wheel's A input, if B XOR its mask bit is 1, that wheel's counter decrements by one.
- R4: Falling edges of A and any change of B, with A held steady, leave the counter unchanged.
- R5: Mask bit 6 inverts the left B phase and mask bit 5 inverts the right B phase. No other mask bit affects either wheel.
- R6: Each counter wraps modulo 65536 in both directions. Carry and borrow pass between the low byte and the high byte (0x00FF+1 = 0x0100, 0x0000-1 = 0xFFFF).
- R7: The left and right wheels count independently. Activity on one wheel never changes the other wheel's counter.
- R8: A cycle with snap_strobe high copies both counters into the four output bytes in one edge. A step taken at that same edge is not included. Without a strobe, the outputs hold their value.
- R9: A mask write with mask_we high is stored at the next clock edge. Every A edge detected after that edge uses the new polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_left_a | input | 1 | Left encoder phase A (asynchronous) |
| enc_left_b | input | 1 | Left encoder phase B (asynchronous) |
| enc_right_a | input | 1 | Right encoder phase A (asynchronous) |
| enc_right_b | input | 1 | Right encoder phase B (asynchronous) |
| mask_we | input | 1 | Polarity mask write enable |
| mask_wdata | input | 8 | Polarity mask write data |
| snap_strobe | input | 1 | Copy both counters to the output bytes |
| left_lo | output | 8 | Snapshot of left counter, bits 7:0 |
| left_hi | output | 8 | Snapshot of left counter, bits 15:8 |
| right_lo | output | 8 | Snapshot of right counter, bits 7:0 |
| right_hi | output | 8 | Snapshot of right counter, bits 15:8 |

## Verification
The collision case is a counter step and a snapshot strobe at the same clock edge. The bench provokes it by raising A and then asserting the strobe in the cycle where the synchronized rising edge is being detected. The first snapshot must hold the value from before the step. A second strobe must then show the stepped value. The scoreboard judges both snapshots from its own model of the counters. Mask polarity, byte carry and borrow, and the independence of the two wheels are each exercised in separate sequences.

// File: rtl/odo_pkg.sv
package odo_pkg;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    function automatic step_dir_e pick_dir(input logic b_level, input logic b_invert);
        return (b_level ^ b_invert) ? STEP_DOWN : STEP_UP;
    endfunction

endpackage

// File: rtl/odo_sync.sv
module odo_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/odo_wheel.sv
module odo_wheel
    import odo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_sync,
    input  logic             b_sync,
    input  logic             b_invert,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic             a_prev;
        logic [CNT_W-1:0] cnt;
    } wheel_state_t;

    wheel_state_t st_d, st_q;
    logic         rise;
    step_dir_e    dir;

    always_comb begin
        st_d        = st_q;
        rise        = a_sync && !st_q.a_prev;
        dir         = pick_dir(b_sync, b_invert);
        st_d.a_prev = a_sync;
        if (rise) begin
            if (dir == STEP_DOWN) st_d.cnt = st_q.cnt - CNT_W'(1);
            else                  st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_UP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !(b_sync ^ b_invert)) |=> (count == CNT_W'($past(count) + CNT_W'(1)))); // R2
    AST_DOWN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (b_sync ^ b_invert)) |=> (count == CNT_W'($past(count) - CNT_W'(1)))); // R3
    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_sync && !st_q.a_prev) |=> $stable(count)); // R4
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (CNT_W'(count - $past(count)) == CNT_W'(1) ||
                             CNT_W'($past(count) - count) == CNT_W'(1))); // R6
endmodule

// File: rtl/odo_dual_counter.sv
module odo_dual_counter #(
    parameter int CNT_W          = 16,
    parameter int MASK_W         = 8,
    parameter int LEFT_MASK_BIT  = 6,
    parameter int RIGHT_MASK_BIT = 5,
    parameter int SYNC_STAGES    = 2,
    localparam int HALF_W        = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_left_a,
    input  logic              enc_left_b,
    input  logic              enc_right_a,
    input  logic              enc_right_b,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              snap_strobe,
    output logic [HALF_W-1:0] left_lo,
    output logic [HALF_W-1:0] left_hi,
    output logic [HALF_W-1:0] right_lo,
    output logic [HALF_W-1:0] right_hi
);
    localparam int NUM_WHEELS = 2;
    localparam int SYNC_W     = 2 * NUM_WHEELS;

    typedef struct packed {
        logic [MASK_W-1:0]                 mask;
        logic [NUM_WHEELS-1:0][CNT_W-1:0]  snap;
    } top_state_t;

    top_state_t                       st_d, st_q;
    logic [SYNC_W-1:0]                enc_raw, enc_sync;
    logic [NUM_WHEELS-1:0][CNT_W-1:0] wheel_cnt;

    // bit order per wheel: {B, A}; wheel 0 = left, wheel 1 = right
    assign enc_raw = {enc_right_b, enc_right_a, enc_left_b, enc_left_a};

    odo_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (enc_raw),
        .dout (enc_sync)
    );

    for (genvar w = 0; w < NUM_WHEELS; w++) begin : g_wheel
        localparam int MBIT = (w == 0) ? LEFT_MASK_BIT : RIGHT_MASK_BIT;
        odo_wheel #(.CNT_W(CNT_W)) u_wheel (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_sync  (enc_sync[2*w]),
            .b_sync  (enc_sync[2*w+1]),
            .b_invert(st_q.mask[MBIT]),
            .count   (wheel_cnt[w])
        );
    end

    always_comb begin
        st_d = st_q;
        if (mask_we)     st_d.mask = mask_wdata;
        if (snap_strobe) st_d.snap = wheel_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_lo  = st_q.snap[0][HALF_W-1:0];
    assign left_hi  = st_q.snap[0][CNT_W-1:HALF_W];
    assign right_lo = st_q.snap[1][HALF_W-1:0];
    assign right_hi = st_q.snap[1][CNT_W-1:HALF_W];

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_strobe |=> $stable({left_hi, left_lo, right_hi, right_lo})); // R8
    AST_SNAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        snap_strobe |=> ({left_hi, left_lo} == $past(wheel_cnt[0]) &&
                         {right_hi, right_lo} == $past(wheel_cnt[1]))); // R8
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (st_q.mask == $past(mask_wdata))); // R9
endmodule

// File: tb/odo_dual_counter_test.sv
module odo_dual_counter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       la = 0, lb = 0, ra = 0, rb = 0;
    logic       mask_we = 0;
    logic [7:0] mask_wdata = 0;
    logic       snap_strobe = 0;
    logic [7:0] left_lo, left_hi, right_lo, right_hi;

    int errors = 0;
    int checks = 0;
    int exp_l = 0, exp_r = 0;
    logic [7:0] mask_model = 0;
    logic pend = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    odo_dual_counter uut (
        .clk(clk), .rst_n(rst_n),
        .enc_left_a(la), .enc_left_b(lb), .enc_right_a(ra), .enc_right_b(rb),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .snap_strobe(snap_strobe),
        .left_lo(left_lo), .left_hi(left_hi), .right_lo(right_lo), .right_hi(right_hi)
    );

    // monitor: compare the snapshot taken at the last edge
    always @(posedge clk) pend <= snap_strobe;
    always @(negedge clk) begin
        if (pend) begin
            logic [31:0] got, want;
            string t;
            got = {left_hi, left_lo, right_hi, right_lo};
            if (exp_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL R8 snapshot with empty scoreboard got=%h expected=none", got);
            end else begin
                want = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s got=%h expected=%h", t, got, want);
                end
            end
        end
    end

    task automatic snap(input string t);
        @(negedge clk);
        exp_q.push_back({exp_l[15:0], exp_r[15:0]});
        tag_q.push_back(t);
        snap_strobe = 1;
        @(negedge clk);
        snap_strobe = 0;
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [7:0] v);
        @(negedge clk);
        mask_we = 1; mask_wdata = v;
        @(negedge clk);
        mask_we = 0;
        mask_model = v;
    endtask

    // wheel 0 = left, 1 = right; down = 1 means expect decrement
    task automatic step(input int wheel, input bit down);
        logic bphys;
        @(negedge clk);
        if (wheel == 0) begin
            bphys = down ^ mask_model[6];
            lb = bphys;
        end else begin
            bphys = down ^ mask_model[5];
            rb = bphys;
        end
        repeat (3) @(negedge clk);
        if (wheel == 0) la = 1; else ra = 1;
        repeat (3) @(negedge clk);
        if (wheel == 0) la = 0; else ra = 0;
        repeat (3) @(negedge clk);
        if (wheel == 0) exp_l = (exp_l + (down ? -1 : 1)) & 16'hFFFF;
        else            exp_r = (exp_r + (down ? -1 : 1)) & 16'hFFFF;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        checks++;
        if ({left_hi, left_lo, right_hi, right_lo} !== 32'h0) begin
            errors++;
            $display("FAIL R1 outputs after reset got=%h expected=0", {left_hi, left_lo, right_hi, right_lo});
        end
        snap("R1 counters zero after reset");

        for (int i = 0; i < 3; i++) step(0, 0);
        snap("R2 R7 left up three, right unchanged");

        step(1, 1); step(1, 1);
        snap("R3 R6 right down twice through zero");

        // B toggles with A low, and A falls: no count
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); lb = ~lb; rb = ~rb;
            repeat (3) @(negedge clk);
        end
        snap("R4 B activity alone does not count");
        @(negedge clk); la = 1; repeat (4) @(negedge clk);
        exp_l = (exp_l + ((lb ^ mask_model[6]) ? -1 : 1)) & 16'hFFFF;
        snap("R4 rising A counts once");
        la = 0; repeat (4) @(negedge clk);
        snap("R4 falling A does not count");

        // mask polarity: physical B = 1 with bit 6 set counts left up
        write_mask(8'h40);
        @(negedge clk); lb = 1; rb = 1; repeat (3) @(negedge clk);
        la = 1; ra = 1; repeat (4) @(negedge clk);
        la = 0; ra = 0; repeat (4) @(negedge clk);
        exp_l = (exp_l + 1) & 16'hFFFF;
        exp_r = (exp_r - 1) & 16'hFFFF;
        snap("R5 R9 bit6 inverts left only");
        write_mask(8'hBF);
        @(negedge clk); la = 1; ra = 1; repeat (4) @(negedge clk);
        la = 0; ra = 0; repeat (4) @(negedge clk);
        exp_l = (exp_l - 1) & 16'hFFFF;
        exp_r = (exp_r + 1) & 16'hFFFF;
        snap("R5 R9 other bits leave left, bit5 inverts right");
        write_mask(8'h00);

        // carry into high byte and borrow back
        exp_l = exp_l; 
        for (int i = 0; i < 256; i++) step(0, 0);
        snap("R6 left carry across bytes");
        for (int i = 0; i < 256; i++) step(0, 1);
        snap("R6 left borrow across bytes");
        for (int i = 0; i < 2; i++) step(1, 0);
        snap("R6 R7 right wraps up to zero");

        // outputs hold without strobe
        held = {left_hi, left_lo, right_hi, right_lo};
        step(0, 0); step(1, 0);
        checks++;
        if ({left_hi, left_lo, right_hi, right_lo} !== held) begin
            errors++;
            $display("FAIL R8 outputs moved without strobe got=%h expected=%h",
                     {left_hi, left_lo, right_hi, right_lo}, held);
        end

        // collision: strobe at the same edge as a left step
        @(negedge clk); lb = 0; repeat (3) @(negedge clk);
        la = 1;
        @(negedge clk);
        @(negedge clk);
        exp_q.push_back({exp_l[15:0], exp_r[15:0]});
        tag_q.push_back("R8 strobe with step keeps old value");
        snap_strobe = 1;
        @(negedge clk);
        snap_strobe = 0;
        exp_l = (exp_l + 1) & 16'hFFFF;
        repeat (3) @(negedge clk);
        la = 0; repeat (3) @(negedge clk);
        snap("R8 next strobe shows step");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule